// File: doc/BRIEF.md
# Error-Compensated Parallel Adder Tree

This block produces one transform output from a set of bit-weighted partial sums. A multiplierless distributed-arithmetic stage supplies nine signed words, one for each bit of a 9-bit two's-complement coefficient. The block shifts every word by its bit weight, adds all of them at once in a balanced adder tree and registers the result. There is no serial shift-accumulate loop, so a new set of partial sums can be accepted on every clock.

Right-shifting the words drops their low-order bits, and that truncation biases the result downward. The block recovers most of this loss. It counts the most significant dropped bit of every shifted word, halves that count with rounding, and adds it at the least significant kept position. The final sum saturates to the output range and does not wrap. With compensation, a 9-bit coefficient precision keeps an accuracy that a plain truncating tree would only reach with more coefficient bits.

Top module: `ec_adder_tree`

## Requirements
- R1: Word k of `part_i` sits at bits [12k+11:12k] and is read as a signed value P_k. When `valid_i` is high, `result_o` in the next cycle equals sat(-P_0 + sum over k=1..8 of floor(P_k / 2^k) + C). Word 0 has negative weight; word k has weight 2^-k.
- R2: Each shifted word is truncated toward minus infinity, as an arithmetic right shift does. For example, P_1 = -1 alone gives a truncated term of -1, and P_2 = -3 alone gives a result of -1.
- R3: Let n be the number of words k = 1..8 whose bit k-1 is set. The compensation term is C = (n+1) >> 1, which rounds half up. So n = 1 gives 1, n = 3 gives 2 and n = 8 gives 4.
- R4: A sum above 2047 gives a result of 2047, and a sum below -2048 gives -2048.
- R5: `valid_o` equals `valid_i` delayed by exactly one clock cycle.
- R6: While `valid_i` is low, `part_i` is ignored and `result_o` holds its last value.
- R7: While `rst_ni` is low, `valid_o` is 0 and `result_o` is 0.
- R8: Take any unsaturated result and the exact value E = -P_0 + sum of P_k * 2^-k. The result minus E lies within [-4, 0.5]. Over many random inputs, the mean absolute error is smaller than that of the same tree without compensation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Partial sums on `part_i` are valid this cycle |
| part_i | input | 108 | Nine signed 12-bit partial sums; word k has weight 2^-k, and word 0 is negative |
| valid_o | output | 1 | `result_o` was updated by the last clock edge |
| result_o | output | 12 | Compensated, saturated signed result |

## Verification
The assertions assume three things about the inputs. `valid_i` and `part_i` carry known values once reset is released. The full-width tree sum never exceeds its internal width; any 12-bit input words guarantee this, so the saturation properties can compare the raw sum directly. The stimulus follows these assumptions by keeping every input driven. It mixes seeded random words over the full signed range with directed words that place a set guard bit on chosen positions, or that push the sum past either output limit. Stretches with `valid_i` low carry fresh random data, which shows that this data is ignored.

// File: rtl/ectree_pkg.sv
package ectree_pkg;
  localparam int unsigned DEF_N_TERMS = 9;
  localparam int unsigned DEF_IN_W    = 12;
  localparam int unsigned DEF_OUT_W   = 12;

  function automatic int unsigned sum_width(int unsigned in_w, int unsigned n_terms);
    return in_w + $clog2(n_terms + 1) + 1;
  endfunction
endpackage

// File: rtl/ectree_shift.sv
module ectree_shift #(
  parameter int unsigned IN_W  = 12,
  parameter int unsigned SUM_W = 17,
  parameter int unsigned SHIFT = 0
) (
  input  logic [IN_W-1:0]         word_i,
  output logic signed [SUM_W-1:0] term_o,
  output logic                    guard_o
);
  logic signed [SUM_W-1:0] word_ext;
  assign word_ext = {{(SUM_W-IN_W){word_i[IN_W-1]}}, word_i};

  if (SHIFT == 0) begin : g_sign
    // sign position carries negative weight
    assign term_o  = -word_ext;
    assign guard_o = 1'b0;
  end else begin : g_frac
    assign term_o  = word_ext >>> SHIFT;
    assign guard_o = word_i[SHIFT-1];
  end
endmodule

// File: rtl/ectree_comp.sv
module ectree_comp #(
  parameter int unsigned N_G   = 9,
  parameter int unsigned CNT_W = $clog2(N_G + 2)
) (
  input  logic [N_G-1:0]   guards_i,
  output logic [CNT_W-1:0] comp_o
);
  logic [CNT_W-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < int'(N_G); i++) cnt = cnt + CNT_W'(guards_i[i]);
    comp_o = (cnt + CNT_W'(1)) >> 1;
  end

  always_comb begin
    if (guards_i == '0) assert (comp_o == '0) else $error("AST_COMP_ZERO"); // R3
  end
endmodule

// File: rtl/ectree_add_tree.sv
module ectree_add_tree #(
  parameter int unsigned N_OPS = 10,
  parameter int unsigned W     = 17
) (
  input  logic [N_OPS*W-1:0]  ops_i,
  output logic signed [W-1:0] sum_o
);
  localparam int unsigned DEPTH  = $clog2(N_OPS);
  localparam int unsigned LEAVES = 1 << DEPTH;

  for (genvar l = 0; l <= DEPTH; l++) begin : g_lvl
    localparam int unsigned CNT = LEAVES >> l;
    logic signed [W-1:0] node [CNT];
    if (l == 0) begin : g_leaf
      for (genvar j = 0; j < CNT; j++) begin : g_in
        if (j < N_OPS) begin : g_op
          assign node[j] = ops_i[j*W +: W];
        end else begin : g_pad
          assign node[j] = '0;
        end
      end
    end else begin : g_add
      for (genvar j = 0; j < CNT; j++) begin : g_sum
        assign node[j] = g_lvl[l-1].node[2*j] + g_lvl[l-1].node[2*j+1];
      end
    end
  end

  assign sum_o = g_lvl[DEPTH].node[0];
endmodule

// File: rtl/ectree_sat.sv
module ectree_sat #(
  parameter int unsigned SUM_W = 17,
  parameter int unsigned OUT_W = 12
) (
  input  logic signed [SUM_W-1:0] sum_i,
  output logic [OUT_W-1:0]        res_o
);
  localparam logic signed [SUM_W-1:0] MAX_S = SUM_W'((1 << (OUT_W-1)) - 1);
  localparam logic signed [SUM_W-1:0] MIN_S = -MAX_S - SUM_W'(1);

  always_comb begin
    if (sum_i > MAX_S)      res_o = {1'b0, {(OUT_W-1){1'b1}}};
    else if (sum_i < MIN_S) res_o = {1'b1, {(OUT_W-1){1'b0}}};
    else                    res_o = sum_i[OUT_W-1:0];
  end
endmodule

// File: rtl/ec_adder_tree.sv
module ec_adder_tree
  import ectree_pkg::*;
#(
  parameter int unsigned N_TERMS = DEF_N_TERMS,
  parameter int unsigned IN_W    = DEF_IN_W,
  parameter int unsigned OUT_W   = DEF_OUT_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [N_TERMS*IN_W-1:0] part_i,
  output logic                    valid_o,
  output logic [OUT_W-1:0]        result_o
);
  localparam int unsigned SUM_W = sum_width(IN_W, N_TERMS);
  localparam int unsigned N_OPS = N_TERMS + 1;
  localparam int unsigned CNT_W = $clog2(N_TERMS + 2);
  localparam logic signed [SUM_W-1:0] MAX_S = SUM_W'((1 << (OUT_W-1)) - 1);
  localparam logic signed [SUM_W-1:0] MIN_S = -MAX_S - SUM_W'(1);
  localparam logic [OUT_W-1:0] OUT_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] OUT_MIN = {1'b1, {(OUT_W-1){1'b0}}};

  logic [N_TERMS-1:0]      guards;
  logic [N_OPS*SUM_W-1:0]  ops_flat;
  logic [CNT_W-1:0]        comp;
  logic signed [SUM_W-1:0] tree_sum;
  logic [OUT_W-1:0]        sat_res;

  for (genvar k = 0; k < N_TERMS; k++) begin : g_term
    logic signed [SUM_W-1:0] term;
    ectree_shift #(.IN_W(IN_W), .SUM_W(SUM_W), .SHIFT(k)) u_shift (
      .word_i (part_i[k*IN_W +: IN_W]),
      .term_o (term),
      .guard_o(guards[k])
    );
    assign ops_flat[k*SUM_W +: SUM_W] = term;
  end

  ectree_comp #(.N_G(N_TERMS), .CNT_W(CNT_W)) u_comp (
    .guards_i(guards),
    .comp_o  (comp)
  );
  assign ops_flat[N_TERMS*SUM_W +: SUM_W] = SUM_W'(comp);

  ectree_add_tree #(.N_OPS(N_OPS), .W(SUM_W)) u_tree (
    .ops_i(ops_flat),
    .sum_o(tree_sum)
  );

  ectree_sat #(.SUM_W(SUM_W), .OUT_W(OUT_W)) u_sat (
    .sum_i(tree_sum),
    .res_o(sat_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= sat_res;
    end
  end

  AST_VALID_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R5
  AST_VALID_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R5
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o)); // R6
  AST_SAT_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (tree_sum > MAX_S)) |=> (result_o == OUT_MAX)); // R4
  AST_SAT_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (tree_sum < MIN_S)) |=> (result_o == OUT_MIN)); // R4
  AST_ZERO_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (part_i == '0)) |=> (result_o == '0)); // R1
endmodule

// File: tb/ec_adder_tree_tb.sv
`timescale 1ns/1ps
module ec_adder_tree_tb_top;
  localparam int N = 9;
  localparam int W = 12;

  logic           clk_i = 1'b0;
  logic           rst_ni;
  logic           valid_i;
  logic [N*W-1:0] part_i;
  logic           valid_o;
  logic [W-1:0]   result_o;

  int n_chk = 0;
  int n_fail = 0;
  int last_res = 0;
  bit done = 0;
  longint sum_c = 0;
  longint sum_t = 0;
  int n_err = 0;

  always #2.5 clk_i = ~clk_i;

  ec_adder_tree dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .part_i(part_i), .valid_o(valid_o), .result_o(result_o)
  );

  function automatic int wrd(logic [N*W-1:0] d, int k);
    return int'($signed(d[k*W +: W]));
  endfunction

  function automatic int model(logic [N*W-1:0] d, bit use_comp);
    int r = -wrd(d, 0);
    int c = 0;
    for (int k = 1; k < N; k++) begin
      r += wrd(d, k) >>> k;
      c += (wrd(d, k) >>> (k-1)) & 1;
    end
    if (use_comp) r += (c + 1) / 2;
    return r;
  endfunction

  function automatic int exact256(logic [N*W-1:0] d);
    int e = -wrd(d, 0) * 256;
    for (int k = 1; k < N; k++) e += wrd(d, k) * (1 << (8 - k));
    return e;
  endfunction

  function automatic int sat(int v);
    if (v > 2047) return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(logic [N*W-1:0] d, bit v, string tag);
    int res;
    int expv;
    valid_i = v;
    part_i  = d;
    @(negedge clk_i);
    res = int'($signed(result_o));
    check(valid_o == v, "R5", int'(valid_o), int'(v));
    expv = v ? sat(model(d, 1'b1)) : last_res;
    check(res == expv, v ? tag : "R6", res, expv);
    last_res = res;
  endtask

  function automatic logic [N*W-1:0] pack1(int k, int val);
    logic [N*W-1:0] d = '0;
    d[k*W +: W] = W'(val);
    return d;
  endfunction

  function automatic logic [N*W-1:0] rnd();
    logic [N*W-1:0] d;
    for (int k = 0; k < N; k++) d[k*W +: W] = W'($urandom);
    return d;
  endfunction

  initial begin
    #500000;
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [N*W-1:0] d;
    void'($urandom(32'd1234));
    rst_ni = 1'b0; valid_i = 1'b0; part_i = '0;
    repeat (3) @(negedge clk_i);
    check(valid_o == 1'b0, "R7", int'(valid_o), 0);
    check(result_o == '0, "R7", int'(result_o), 0);
    rst_ni = 1'b1;

    drive('0, 1'b1, "R1");
    drive(pack1(0, 5), 1'b1, "R1");               // -5
    drive(pack1(1, -1), 1'b1, "R2");              // floor -1, comp 1 -> 0
    drive(pack1(2, -3), 1'b1, "R2");              // -1
    drive(pack1(1, 1), 1'b1, "R3");               // n=1 -> 1
    d = pack1(1, 1) | pack1(2, 2) | pack1(3, 4);
    drive(d, 1'b1, "R3");                         // n=3 -> 2
    d = '0;
    for (int k = 1; k < N; k++) d[k*W +: W] = W'(1 << (k-1));
    drive(d, 1'b1, "R3");                         // n=8 -> 4
    d = pack1(0, -2048);
    for (int k = 1; k < N; k++) d[k*W +: W] = W'(2047);
    drive(d, 1'b1, "R4");                         // 2047
    d = pack1(0, 2047);
    for (int k = 1; k < N; k++) d[k*W +: W] = W'(-2048);
    drive(d, 1'b1, "R4");                         // -2048
    drive(pack1(0, -2047), 1'b1, "R4");           // 2047 exactly, no clip
    for (int i = 0; i < 6; i++) drive(rnd(), 1'b0, "R6");

    for (int i = 0; i < 3000; i++) begin
      bit v;
      d = rnd();
      v = ($urandom % 5) != 0;
      drive(d, v, "R1");
      if (v && model(d, 1'b1) == sat(model(d, 1'b1))) begin
        int diff = model(d, 1'b1) * 256 - exact256(d);
        check(diff <= 128 && diff >= -1024, "R8", diff, 0);
        sum_c += iabs(diff);
        sum_t += iabs(model(d, 1'b0) * 256 - exact256(d));
        n_err++;
      end
    end
    check(n_err > 100 && sum_c < sum_t, "R8", int'(sum_c), int'(sum_t));

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule